// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns a queue of instruction beats into pin activity on an 8-bit asynchronous NAND flash bus. An operation is a run of beats that ends with a beat flagged as last. The block pulls chip enable low when it accepts the first beat of an operation and releases it once the last beat has finished. A timed-out ready wait releases it at once instead. The host pushes beats over a valid/ready handshake and receives read bytes on a one-cycle valid stream. Each operation ends with a done pulse that carries an error flag.

Each beat carries a kind code, a byte, a flag that keeps the address latch open, the end-of-operation flag and a count. For a read the count is the number of bytes. For a ready wait it is the poll limit. The write and read strobe widths come from minimum timings given in picoseconds. The block turns them into whole clock cycles, rounding up, so the strobes track the flash timing without a software divide. The data-bus driver keeps its direction as state and switches it only when a write follows a read, or a read follows a write.

Top module: `nand_op_seq`

## Requirements
- R1: While reset is low: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_wp_n` is 0, `nand_cle` and `nand_ale` are 0, `nand_dq_oe` is 0, and `op_done` and `rd_valid` are 0.
- R2: `nand_wp_n` takes the value of `wp_en` one clock later, so write protect is active until software sets the enable bit and returns when the bit is cleared.
- R3: `nand_ce_n` falls exactly once per operation, on the edge that accepts the operation's first beat, and stays low until the operation finishes. `op_done` pulses for one cycle in the first cycle with `nand_ce_n` high. It is high for at least one cycle before the next operation begins.
- R4: Kind 0 (command) raises `nand_cle`, drives `ins_byte` on `nand_dq_o` and gives exactly one write strobe. It then drops `nand_cle` one cycle after the strobe ends.
- R5: Kind 1 (address) gives one write strobe per beat with `nand_ale` high. `nand_ale` stays high across address beats flagged `ins_more`=1 and drops one cycle after the strobe of the first address beat with `ins_more`=0, so N address bytes produce one rising edge of `nand_ale`.
- R6: Every write strobe (kinds 0, 1 and 2) holds `nand_we_n` low for max(1, ceil(`twp_ps`/CLK_PS)) cycles. `nand_dq_o` and the latch enables are set at least one cycle before the fall and held until one cycle after the rise.
- R7: Kind 3 (read) gives max(1, `ins_count`) read strobes. Each holds `nand_re_n` low for max(1, ceil(`trp_ps`/CLK_PS)) cycles, with one high cycle between strobes. `nand_dq_i` is captured on the last low cycle and appears on `rd_data` with a one-cycle `rd_valid` pulse as `nand_re_n` rises.
- R8: `nand_dq_oe` is 0 after reset. A write beat (kinds 0, 1 and 2) sets it to 1 before its strobe, and a read beat clears it to 0 before its first strobe. No other beat changes it, and it keeps its value across operations.
- R9: Kind 4 (ready wait) samples `nand_rb` once per cycle for up to max(1, `ins_count`) cycles. If it sees `nand_rb` high, the operation continues. If it never does, `nand_ce_n` rises at once and the remaining beats of the operation are accepted and discarded with no strobe. Then `op_done` pulses with `op_err`=1.
- R10: `nand_we_n` and `nand_re_n` are never low together. Any strobe is preceded by at least two cycles with the other strobe high. `nand_cle` and `nand_ale` do not change while `nand_we_n` is low, nor in the cycle it rises.
- R11: An operation that completes without a timeout ends with `op_err`=0. Kind codes 5 to 7 produce no strobe and no latch activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_en | input | 1 | Software bit that releases write protect |
| twp_ps | input | PS_W | Minimum write pulse width in ps |
| trp_ps | input | PS_W | Minimum read pulse width in ps |
| ins_valid | input | 1 | Instruction beat valid |
| ins_ready | output | 1 | Instruction beat accepted when high with valid |
| ins_kind | input | 3 | 0 command, 1 address, 2 write, 3 read, 4 ready wait |
| ins_byte | input | 8 | Opcode, address or data byte |
| ins_more | input | 1 | Address latch stays open after this address beat |
| ins_last | input | 1 | Last beat of the operation |
| ins_count | input | CNT_W | Read byte count or ready poll limit |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| op_done | output | 1 | Operation finished pulse |
| op_err | output | 1 | Timeout flag, valid with op_done |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The bound checker watches the pin-level rules on every cycle: the two strobes never overlap, strobes keep their spacing, the latch enables hold still around a write pulse, and each strobe falls only while chip enable is low. It also checks that the bus direction matches the strobe in progress, that write data holds still during a pulse, and that the done pulse and read-valid pulse line up with chip enable and the read enable edge. Strobe widths against the picosecond rounding, byte order and latch grouping, the timeout length and the discarded remainder of an operation, and the lazy direction state carried between operations are properties of whole scenarios, so only the bench's sweeps show them.

// File: rtl/nand_op_seq.sv
`timescale 1ns/1ps
module nand_op_seq #(
  parameter int CLK_PS = 8000,
  parameter int PS_W   = 16,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_en,
  input  logic [PS_W-1:0]  twp_ps,
  input  logic [PS_W-1:0]  trp_ps,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [2:0]       ins_kind,
  input  logic [7:0]       ins_byte,
  input  logic             ins_more,
  input  logic             ins_last,
  input  logic [CNT_W-1:0] ins_count,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             op_done,
  output logic             op_err,
  output logic             nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_wp_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb
);
  localparam int QW = PS_W + 1;
  localparam logic [2:0] K_CMD = 3'd0, K_ADDR = 3'd1, K_WRITE = 3'd2,
                         K_READ = 3'd3, K_WAIT = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_WSET, S_WPUL, S_RSET, S_RPUL, S_POLL, S_GAP, S_DRAIN
  } st_t;

  st_t              st;
  logic [2:0]       kind_q;
  logic             more_q, last_q;
  logic [CNT_W-1:0] left;
  logic [QW-1:0]    pcnt;
  logic [QW-1:0]    twp_q, trp_q, twp_cyc, trp_cyc;
  logic             accept;

  assign twp_q   = ({1'b0, twp_ps} + QW'(CLK_PS - 1)) / QW'(CLK_PS);
  assign trp_q   = ({1'b0, trp_ps} + QW'(CLK_PS - 1)) / QW'(CLK_PS);
  assign twp_cyc = (twp_q == '0) ? QW'(1) : twp_q;
  assign trp_cyc = (trp_q == '0) ? QW'(1) : trp_q;

  assign ins_ready = (st == S_IDLE) || (st == S_FETCH) || (st == S_DRAIN);
  assign accept    = ins_valid && ins_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind_q <= '0;
      more_q <= 1'b0;
      last_q <= 1'b0;
      left <= '0;
      pcnt <= '0;
      nand_ce_n <= 1'b1;
      nand_we_n <= 1'b1;
      nand_re_n <= 1'b1;
      nand_wp_n <= 1'b0;
      nand_cle <= 1'b0;
      nand_ale <= 1'b0;
      nand_dq_o <= '0;
      nand_dq_oe <= 1'b0;
      rd_valid <= 1'b0;
      rd_data <= '0;
      op_done <= 1'b0;
      op_err <= 1'b0;
    end else begin
      nand_wp_n <= wp_en;
      rd_valid <= 1'b0;
      op_done <= 1'b0;
      case (st)
        S_IDLE, S_FETCH: begin
          if (accept) begin
            nand_ce_n <= 1'b0;
            kind_q <= ins_kind;
            more_q <= ins_more;
            last_q <= ins_last;
            left <= (ins_count == '0) ? CNT_W'(1) : ins_count;
            case (ins_kind)
              K_CMD: begin
                nand_cle <= 1'b1;
                nand_dq_o <= ins_byte;
                nand_dq_oe <= 1'b1;
                st <= S_WSET;
              end
              K_ADDR: begin
                nand_ale <= 1'b1;
                nand_dq_o <= ins_byte;
                nand_dq_oe <= 1'b1;
                st <= S_WSET;
              end
              K_WRITE: begin
                nand_dq_o <= ins_byte;
                nand_dq_oe <= 1'b1;
                st <= S_WSET;
              end
              K_READ: begin
                nand_dq_oe <= 1'b0;
                st <= S_RSET;
              end
              K_WAIT:  st <= S_POLL;
              default: st <= S_GAP;
            endcase
          end
        end
        S_WSET: begin
          nand_we_n <= 1'b0;
          pcnt <= twp_cyc;
          st <= S_WPUL;
        end
        S_WPUL: begin
          if (pcnt <= QW'(1)) begin
            nand_we_n <= 1'b1;
            st <= S_GAP;
          end else begin
            pcnt <= pcnt - QW'(1);
          end
        end
        S_RSET: begin
          nand_re_n <= 1'b0;
          pcnt <= trp_cyc;
          st <= S_RPUL;
        end
        S_RPUL: begin
          if (pcnt <= QW'(1)) begin
            nand_re_n <= 1'b1;
            rd_data <= nand_dq_i;
            rd_valid <= 1'b1;
            st <= S_GAP;
          end else begin
            pcnt <= pcnt - QW'(1);
          end
        end
        S_POLL: begin
          if (nand_rb) begin
            st <= S_GAP;
          end else if (left <= CNT_W'(1)) begin
            nand_ce_n <= 1'b1;
            nand_cle <= 1'b0;
            nand_ale <= 1'b0;
            if (last_q) begin
              op_done <= 1'b1;
              op_err <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_DRAIN;
            end
          end else begin
            left <= left - CNT_W'(1);
          end
        end
        S_GAP: begin
          if (kind_q == K_READ && left > CNT_W'(1)) begin
            nand_re_n <= 1'b0;
            pcnt <= trp_cyc;
            left <= left - CNT_W'(1);
            st <= S_RPUL;
          end else begin
            if (kind_q == K_CMD) nand_cle <= 1'b0;
            if (kind_q == K_ADDR && !more_q) nand_ale <= 1'b0;
            if (last_q) begin
              nand_ce_n <= 1'b1;
              nand_cle <= 1'b0;
              nand_ale <= 1'b0;
              op_done <= 1'b1;
              op_err <= 1'b0;
              st <= S_IDLE;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_DRAIN: begin
          if (accept && ins_last) begin
            op_done <= 1'b1;
            op_err <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_op_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_en,
  input logic       rd_valid,
  input logic       op_done,
  input logic       nand_ce_n,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_wp_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe
);
  AST_WP_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    nand_wp_n |-> $past(wp_en)); // R2
  AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R3
  AST_DONE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> nand_ce_n); // R3
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> $stable(nand_dq_o)); // R6
  AST_RDV_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(nand_re_n)); // R7
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R8
  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R10
  AST_WE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> ($past(nand_re_n) && $past(nand_re_n, 2))); // R10
  AST_RE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> ($past(nand_we_n) && $past(nand_we_n, 2))); // R10
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || $rose(nand_we_n)) |-> $stable({nand_cle, nand_ale})); // R10
endmodule

bind nand_op_seq nand_op_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_en(wp_en), .rd_valid(rd_valid),
  .op_done(op_done), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe)
);

// File: tb/sim_nand_op_seq.sv
`timescale 1ns/1ps
module sim_nand_op_seq;
  localparam int CLK_PS = 8000;
  localparam int PS_W = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wp_en, ins_valid, ins_ready, ins_more, ins_last;
  logic [PS_W-1:0] twp_ps, trp_ps;
  logic [2:0] ins_kind;
  logic [7:0] ins_byte, rd_data, nand_dq_o, nand_dq_i;
  logic [CNT_W-1:0] ins_count;
  logic rd_valid, op_done, op_err, nand_ce_n, nand_we_n, nand_re_n, nand_wp_n;
  logic nand_cle, nand_ale, nand_dq_oe, nand_rb;

  int nchk = 0, nfail = 0, ops = 0;

  int nw = 0, wcur = 0, nr = 0, rcur = 0, nrd = 0, ndone = 0, nale = 0;
  int nfall = 0, clow = 0, lastlow = 0, overlap = 0;
  logic ale_prev = 1'b0, ce_prev = 1'b1;
  int wwid [1024];
  logic [7:0] wbyte [1024];
  logic wcle [1024];
  logic wale [1024];
  int rwid [1024];
  logic [7:0] rdat [1024];
  logic derr [1024];

  assign nand_dq_i = 8'(8'h3C + nr * 7);

  nand_op_seq #(.CLK_PS(CLK_PS), .PS_W(PS_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_en(wp_en), .twp_ps(twp_ps), .trp_ps(trp_ps),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_kind(ins_kind),
    .ins_byte(ins_byte), .ins_more(ins_more), .ins_last(ins_last),
    .ins_count(ins_count), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_done(op_done), .op_err(op_err), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) begin
        if (wcur == 0) begin
          wbyte[nw % 1024] <= nand_dq_o;
          wcle[nw % 1024] <= nand_cle;
          wale[nw % 1024] <= nand_ale;
        end
        wcur <= wcur + 1;
      end else if (wcur > 0) begin
        wwid[nw % 1024] <= wcur;
        nw <= nw + 1;
        wcur <= 0;
      end
      if (!nand_re_n) rcur <= rcur + 1;
      else if (rcur > 0) begin
        rwid[nr % 1024] <= rcur;
        nr <= nr + 1;
        rcur <= 0;
      end
      if (rd_valid) begin
        rdat[nrd % 1024] <= rd_data;
        nrd <= nrd + 1;
      end
      if (op_done) begin
        derr[ndone % 1024] <= op_err;
        ndone <= ndone + 1;
      end
      if (nand_ale && !ale_prev) nale <= nale + 1;
      ale_prev <= nand_ale;
      if (!nand_ce_n && ce_prev) nfall <= nfall + 1;
      ce_prev <= nand_ce_n;
      if (!nand_ce_n) clow <= clow + 1;
      else if (clow > 0) begin
        lastlow <= clow;
        clow <= 0;
      end
      if (!nand_we_n && !nand_re_n) overlap <= overlap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pw(input int ps);
    return (ps == 0) ? 1 : (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic logic [7:0] rexp(input int j);
    return 8'(8'h3C + j * 7);
  endfunction

  task automatic send(input logic [2:0] k, input logic [7:0] b, input logic m,
                      input logic l, input int c);
    ins_kind = k;
    ins_byte = b;
    ins_more = m;
    ins_last = l;
    ins_count = CNT_W'(c);
    ins_valid = 1'b1;
    while (!ins_ready) @(negedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (ndone < ops && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(ndone >= ops, "R3 done pulse", ndone, ops);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int ps_list [7] = '{0, 1, 7999, 8000, 8001, 16001, 65535};
    int bw, br, brd, ba, bd;
    rst_n = 1'b0; wp_en = 1'b0; ins_valid = 1'b0; ins_kind = '0; ins_byte = '0;
    ins_more = 1'b0; ins_last = 1'b0; ins_count = '0; nand_rb = 1'b1;
    twp_ps = 16'd20000; trp_ps = 16'd8000;
    repeat (3) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk(!nand_wp_n && !nand_cle && !nand_ale, "R1 wp/latches", {nand_wp_n, nand_cle, nand_ale}, 0);
    chk(!nand_dq_oe && !op_done && !rd_valid, "R1 bus input", {nand_dq_oe, op_done, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!nand_wp_n, "R2 protect held", nand_wp_n, 0);
    wp_en = 1'b1;
    @(negedge clk);
    chk(nand_wp_n, "R2 protect released", nand_wp_n, 1);
    wp_en = 1'b0;
    @(negedge clk);
    chk(!nand_wp_n, "R2 protect reasserted", nand_wp_n, 0);
    wp_en = 1'b1;

    // R4 R5 R6 R11: command, 3 address bytes, 4 data bytes, command, ready wait
    bw = nw; ba = nale; bd = ndone; ops++;
    send(3'd0, 8'h80, 0, 0, 0);
    for (int i = 0; i < 3; i++) send(3'd1, 8'(8'h11 * (i + 1)), i < 2, 0, 0);
    for (int i = 0; i < 4; i++) send(3'd2, 8'(8'hC0 + i), 0, 0, 0);
    send(3'd0, 8'h10, 0, 0, 0);
    send(3'd4, 8'h00, 0, 1, 50);
    wait_done();
    chk(nw - bw == 9, "R4 strobe count", nw - bw, 9);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] eb;
      eb = (i == 0) ? 8'h80 : (i < 4) ? 8'(8'h11 * i) : (i < 8) ? 8'(8'hC0 + i - 4) : 8'h10;
      chk(wbyte[bw + i] == eb, "R6 byte on bus", wbyte[bw + i], eb);
      chk(wcle[bw + i] == (i == 0 || i == 8), "R4 command latch", wcle[bw + i], (i == 0 || i == 8));
      chk(wale[bw + i] == (i >= 1 && i <= 3), "R5 address latch", wale[bw + i], (i >= 1 && i <= 3));
      chk(wwid[bw + i] == 3, "R6 write width", wwid[bw + i], 3);
    end
    chk(nale - ba == 1, "R5 one latch window", nale - ba, 1);
    chk(derr[bd] == 1'b0, "R11 no error", derr[bd], 0);
    chk(nand_dq_oe, "R8 output kept after write op", nand_dq_oe, 1);
    chk(!nand_ale && !nand_cle && nand_ce_n, "R3 idle after op", {nand_ce_n, nand_ale, nand_cle}, 4);

    // R6 R7: pulse width sweep
    for (int i = 0; i < 7; i++) begin
      twp_ps = PS_W'(ps_list[i]);
      trp_ps = PS_W'(ps_list[(i + 3) % 7]);
      bw = nw; br = nr; brd = nrd; ops++;
      send(3'd0, 8'hAA, 0, 0, 0);
      send(3'd3, 8'h00, 0, 1, 2);
      wait_done();
      chk(wwid[bw] == pw(ps_list[i]), "R6 write width sweep", wwid[bw], pw(ps_list[i]));
      for (int j = 0; j < 2; j++) begin
        chk(rwid[br + j] == pw(ps_list[(i + 3) % 7]), "R7 read width sweep",
            rwid[br + j], pw(ps_list[(i + 3) % 7]));
        chk(rdat[brd + j] == rexp(br + j), "R7 read data", rdat[brd + j], rexp(br + j));
      end
      chk(!nand_dq_oe, "R8 input after read", nand_dq_oe, 0);
    end

    // R7: read length sweep
    twp_ps = 16'd8000; trp_ps = 16'd16000;
    for (int n = 0; n < 5; n++) begin
      int e;
      e = (n == 0) ? 1 : n;
      br = nr; brd = nrd; ops++;
      send(3'd3, 8'h00, 0, 1, n);
      wait_done();
      chk(nr - br == e, "R7 strobe count", nr - br, e);
      chk(nrd - brd == e, "R7 byte count", nrd - brd, e);
      for (int j = 0; j < e; j++)
        chk(rdat[brd + j] == rexp(br + j), "R7 read data order", rdat[brd + j], rexp(br + j));
    end

    // R8: direction only changes on the opposite transfer
    ops++; send(3'd4, 8'h00, 0, 1, 4); wait_done();
    chk(!nand_dq_oe, "R8 wait keeps input", nand_dq_oe, 0);
    ops++; send(3'd2, 8'h5A, 0, 1, 0); wait_done();
    chk(nand_dq_oe, "R8 write turns output", nand_dq_oe, 1);
    ops++; send(3'd4, 8'h00, 0, 1, 4); wait_done();
    chk(nand_dq_oe, "R8 wait keeps output", nand_dq_oe, 1);
    ops++; send(3'd5, 8'h00, 0, 1, 0); wait_done();
    chk(nand_dq_oe, "R8 unknown kind keeps output", nand_dq_oe, 1);

    // R9: timeout length sweep, chip enable low for max(1,T) cycles
    nand_rb = 1'b0;
    for (int t = 0; t < 5; t++) begin
      bd = ndone; ops++;
      send(3'd4, 8'h00, 0, 1, t);
      wait_done();
      chk(derr[bd] == 1'b1, "R9 timeout error", derr[bd], 1);
      chk(lastlow == ((t == 0) ? 1 : t), "R9 poll length", lastlow, (t == 0) ? 1 : t);
    end

    // R9: ready arrives before the limit
    bd = ndone; ops++;
    send(3'd4, 8'h00, 0, 1, 20);
    repeat (6) @(negedge clk);
    nand_rb = 1'b1;
    wait_done();
    chk(derr[bd] == 1'b0, "R9 ready in time", derr[bd], 0);

    // R9: abort skips the remainder of the operation
    nand_rb = 1'b0;
    bw = nw; bd = ndone; ba = nale; ops++;
    send(3'd0, 8'h70, 0, 0, 0);
    send(3'd4, 8'h00, 0, 0, 3);
    send(3'd1, 8'h22, 0, 0, 0);
    chk(nand_ce_n, "R9 chip enable released on timeout", nand_ce_n, 1);
    send(3'd2, 8'h55, 0, 1, 0);
    wait_done();
    chk(nw - bw == 1, "R9 skipped beats make no strobe", nw - bw, 1);
    chk(nale == ba, "R9 skipped address opens no latch", nale - ba, 0);
    chk(derr[bd] == 1'b1, "R9 abort error flag", derr[bd], 1);
    nand_rb = 1'b1;

    // R11: unknown kind codes do nothing on the bus
    for (int k = 5; k < 8; k++) begin
      bw = nw; br = nr; bd = ndone; ops++;
      send(3'(k), 8'hFF, 0, 1, 0);
      wait_done();
      chk(nw == bw && nr == br, "R11 unknown kind silent", nw - bw + nr - br, 0);
      chk(derr[bd] == 1'b0, "R11 unknown kind no error", derr[bd], 0);
    end

    // R3: back-to-back operations, one chip enable window each
    ops++; send(3'd0, 8'h01, 0, 1, 0);
    ops++; send(3'd0, 8'h02, 0, 1, 0);
    wait_done();
    chk(nfall == ops, "R3 one enable window per op", nfall, ops);
    chk(overlap == 0, "R10 strobes never overlap", overlap, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule